// File: doc/BRIEF.md
# Banked SPI Register Command Decoder

This block is the serial front end of a small network controller. An SPI host (mode 0, active-low chip select) sends a command byte whose upper three bits choose an operation and whose lower five bits choose a register. The block reads, writes, sets bits in or clears bits in a register file of four banks. Addresses 0x1B to 0x1F are common to all banks, and bits 1:0 of the register at 0x1F pick the bank that serves the other addresses. Each command is framed by its own chip-select assertion.

Two commands move bytes between the SPI link and a buffer port made of plain read and write strobes. The memory behind that port lies outside the block and advances its own pointer. One command byte performs a soft reset of the register file. Some register ranges put one dummy byte on the line ahead of the valid data, and the host has to skip it. The SPI pins are sampled in the system clock domain, so SCK must stay well below the system clock rate.

Top module: `spi_cmd_regbank`

## Requirements
- R1: A command byte is shifted in MSB first on rising SCK edges. Bits 7:5 are the opcode: 000 register read, 001 buffer read, 010 register write, 011 buffer write, 100 bit set, 101 bit clear. Bits 4:0 are the register address. A buffer command ignores its address field, and 0x3A and 0x7A are the usual buffer command bytes.
- R2: On a register read, every byte after the command byte shifts out the addressed register MSB first, changing only on falling SCK edges. Further bytes repeat the value. MISO does not change on any other edge.
- R3: A register write loads the first data byte once its eighth rising SCK edge has been received. Bytes after that byte within the same command change nothing.
- R4: Bit set ORs the data byte into the addressed register. Bit clear ANDs the register with the inverted data byte.
- R5: Bits 1:0 of register 0x1F select which of four banks serves addresses 0x00 to 0x1A. Addresses 0x1B to 0x1F reach the same five registers whatever the bank.
- R6: A read of bank 2 at addresses 0x00 to 0x1A, or of bank 3 at 0x00 to 0x05 or 0x0A, returns one 0x00 dummy byte before the register value. Every other read returns the value in the first data byte.
- R7: A buffer read issues one read strobe when the command byte completes and one more after each completed data byte. The byte on the buffer read data input in the cycle after a strobe is the next byte shifted out.
- R8: A buffer write issues exactly one write strobe for each completed data byte, carrying that byte. It issues no read strobes.
- R9: Command byte 0xFF clears every register in all banks, which returns the bank to 0. Opcodes 110 and 111 with any other address leave all registers unchanged.
- R10: Raising chip select before a byte is complete aborts the command without changing any register or issuing any strobe. The next chip-select assertion starts a fresh command byte.
- R11: After reset, all registers read 0x00, MISO is low and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI pins are oversampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, driven low while deselected |
| buf_rd_stb | output | 1 | One-cycle buffer read request |
| buf_rdata | input | 8 | Buffer read data, valid the cycle after buf_rd_stb |
| buf_wr_stb | output | 1 | One-cycle buffer write request |
| buf_wdata | output | 8 | Buffer write data, valid with buf_wr_stb |

## Verification
On every cycle the assertions check several timing and exclusion rules. MISO may move only on a falling SCK edge. A register update or a buffer write strobe may follow only a completed byte. Chip-select release stops all strobes. The bank bits change only through a write to 0x1F or a soft reset, and set and clear act on them as R4 states. Only the directed scenarios can show the data itself: which bank answers, the dummy-byte ranges, the sequence of buffer bytes, and that aborted or undefined commands leave the registers unchanged.

// File: rtl/spi_regbank_pkg.sv
// Package: shared constants, opcode and write-kind types for the banked
// SPI register decoder. Assumes an 8-bit register width and a 5-bit address.
package spi_regbank_pkg;

    localparam int REG_W        = 8;
    localparam int ADDR_W       = 5;
    localparam int OP_W         = 3;
    localparam int NBANKS       = 4;
    localparam int BANK_W       = $clog2(NBANKS);
    localparam int SHARED_FIRST = 27;   // first address common to all banks

    localparam logic [REG_W-1:0] CMD_SOFT_RESET = 8'hFF;

    typedef enum logic [OP_W-1:0] {
        OP_RD_REG  = 3'b000,
        OP_RD_BUF  = 3'b001,
        OP_WR_REG  = 3'b010,
        OP_WR_BUF  = 3'b011,
        OP_BIT_SET = 3'b100,
        OP_BIT_CLR = 3'b101,
        OP_RSVD6   = 3'b110,
        OP_RSVD7   = 3'b111
    } opcode_e;

    typedef enum logic [1:0] {
        WOP_LOAD = 2'd0,
        WOP_SET  = 2'd1,
        WOP_CLR  = 2'd2
    } wr_kind_e;

    // Reads of these bank/address pairs are preceded by one dummy byte.
    function automatic logic needs_dummy(input logic [BANK_W-1:0] bank,
                                         input logic [ADDR_W-1:0] addr);
        logic slow;
        slow = 1'b0;
        if (bank == 2'd2 && addr <= 5'h1A) slow = 1'b1;
        if (bank == 2'd3 && (addr <= 5'h05 || addr == 5'h0A)) slow = 1'b1;
        return slow;
    endfunction

endpackage

// File: rtl/spi_edge_sync.sv
// Module: spi_edge_sync
// Brings SCK, chip select and MOSI into the system clock domain through
// STAGES flops each (equal latency keeps their relative timing) and turns
// SCK transitions into one-cycle edge pulses, qualified by chip select.
// Assumes SCK high and low phases each last several system clocks.
module spi_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic cs_n_in,
    input  logic mosi_in,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_active,
    output logic mosi_s
);

    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sck_pipe;
    logic [STAGES-1:0] cs_pipe;
    logic [STAGES-1:0] mosi_pipe;
    logic              sck_last;

    // Synchronizer chains plus the delayed SCK copy used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_pipe  <= '0;
            cs_pipe   <= '1;
            mosi_pipe <= '0;
            sck_last  <= 1'b0;
        end else begin
            sck_pipe  <= {sck_pipe[TOP-1:0], sck_in};
            cs_pipe   <= {cs_pipe[TOP-1:0], cs_n_in};
            mosi_pipe <= {mosi_pipe[TOP-1:0], mosi_in};
            sck_last  <= sck_pipe[TOP];
        end
    end

    assign cs_active = ~cs_pipe[TOP];
    assign sck_rise  = cs_active &  sck_pipe[TOP] & ~sck_last;
    assign sck_fall  = cs_active & ~sck_pipe[TOP] &  sck_last;
    assign mosi_s    = mosi_pipe[TOP];

endmodule

// File: rtl/spi_byte_shifter.sv
// Module: spi_byte_shifter
// Mode-0 byte framing: samples MOSI on rising edges and pulses byte_done
// with the assembled byte after every W bits; shifts tx_byte out MSB first
// on falling edges, loading it on the first falling edge of each byte slot.
// Assumes tx_byte is settled by the falling edge that follows byte_done.
module spi_byte_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_active,
    input  logic         sck_rise,
    input  logic         sck_fall,
    input  logic         mosi_s,
    input  logic [W-1:0] tx_byte,
    output logic [W-1:0] rx_byte,
    output logic         byte_done,
    output logic         miso
);

    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);

    logic [CNT_W-1:0] bit_cnt;
    logic [W-1:0]     rx_sr;
    logic [W-1:0]     tx_sr;

    // Receive side: bit counter, input shift register and byte completion.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_active) begin
            bit_cnt   <= '0;
            rx_sr     <= '0;
            byte_done <= 1'b0;
            rx_byte   <= '0;
        end else begin
            byte_done <= 1'b0;
            if (sck_rise) begin
                rx_sr   <= {rx_sr[W-2:0], mosi_s};
                bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
                if (bit_cnt == LAST_BIT) begin
                    byte_done <= 1'b1;
                    rx_byte   <= {rx_sr[W-2:0], mosi_s};
                end
            end
        end
    end

    // Transmit side: load at the start of a byte slot, shift otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_active) begin
            miso  <= 1'b0;
            tx_sr <= '0;
        end else if (sck_fall) begin
            if (bit_cnt == '0) begin
                miso  <= tx_byte[W-1];
                tx_sr <= {tx_byte[W-2:0], 1'b0};
            end else begin
                miso  <= tx_sr[W-1];
                tx_sr <= {tx_sr[W-2:0], 1'b0};
            end
        end
    end

    // R2: MISO holds its value except on a falling SCK edge.
    assert_miso_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_active && !sck_fall) |=> $stable(miso));

    // R1: a completed byte is always the result of a rising SCK edge.
    assert_byte_on_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> $past(sck_rise));

endmodule

// File: rtl/spi_reg_file.sv
// Module: spi_reg_file
// Register storage: NBANKS banks of SHARED_FIRST bytes plus the registers
// from SHARED_FIRST to the top address, common to all banks. The two low
// bits of the top register select the bank. Writes load, OR in or clear
// bits; soft_rst clears everything. Read port is combinational.
module spi_reg_file
    import spi_regbank_pkg::*;
#(
    parameter int DATA_W       = REG_W,
    parameter int AW           = ADDR_W,
    parameter int BANKS        = NBANKS,
    parameter int FIRST_SHARED = SHARED_FIRST
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      soft_rst,
    input  logic                      wr_en,
    input  wr_kind_e                  wr_kind,
    input  logic [AW-1:0]             wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [AW-1:0]             rd_addr,
    output logic [DATA_W-1:0]         rd_data,
    output logic [$clog2(BANKS)-1:0]  bank
);

    localparam int NREGS   = 2 ** AW;
    localparam int NSHARED = NREGS - FIRST_SHARED;
    localparam int BW      = $clog2(BANKS);
    localparam logic [AW-1:0] SHARED_BASE = AW'(FIRST_SHARED);
    localparam logic [AW-1:0] TOP_ADDR    = '1;

    logic [DATA_W-1:0]            shared_q [NSHARED];
    logic [BANKS-1:0][DATA_W-1:0] bank_rd;
    logic                         banked_side;

    // Combine the current value with the write data according to the kind.
    function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] cur,
                                                input logic [DATA_W-1:0] d,
                                                input wr_kind_e k);
        case (k)
            WOP_SET: return cur | d;
            WOP_CLR: return cur & ~d;
            default: return d;
        endcase
    endfunction

    assign banked_side = (wr_addr < SHARED_BASE);

    // Registers common to all banks, including the bank selector.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            for (int s = 0; s < NSHARED; s++) shared_q[s] <= '0;
        end else if (wr_en && !banked_side) begin
            for (int s = 0; s < NSHARED; s++) begin
                if (wr_addr == SHARED_BASE + AW'(s))
                    shared_q[s] <= merge(shared_q[s], wr_data, wr_kind);
            end
        end
    end

    assign bank = shared_q[NSHARED-1][BW-1:0];

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            logic [DATA_W-1:0] regs_q [FIRST_SHARED];
            logic [DATA_W-1:0] rd_word;
            logic              hit;

            assign hit = wr_en && banked_side && (bank == BW'(b));

            // Per-bank storage, written only while this bank is selected.
            always_ff @(posedge clk) begin
                if (!rst_n || soft_rst) begin
                    for (int r = 0; r < FIRST_SHARED; r++) regs_q[r] <= '0;
                end else if (hit) begin
                    for (int r = 0; r < FIRST_SHARED; r++) begin
                        if (wr_addr == AW'(r))
                            regs_q[r] <= merge(regs_q[r], wr_data, wr_kind);
                    end
                end
            end

            // Per-bank read selection.
            always_comb begin
                rd_word = '0;
                for (int r = 0; r < FIRST_SHARED; r++) begin
                    if (rd_addr == AW'(r)) rd_word = regs_q[r];
                end
            end

            assign bank_rd[b] = rd_word;
        end
    endgenerate

    // Final read mux: common registers override the banked word.
    always_comb begin
        rd_data = bank_rd[bank];
        for (int s = 0; s < NSHARED; s++) begin
            if (rd_addr == SHARED_BASE + AW'(s)) rd_data = shared_q[s];
        end
    end

    // R5: the bank changes only through a write to the top register or a soft reset.
    assert_bank_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wr_addr == TOP_ADDR) && !soft_rst) |=> $stable(bank));

    // R4: a bit set on the selector leaves every set data bit high.
    assert_bit_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == WOP_SET && wr_addr == TOP_ADDR && !soft_rst)
        |=> ((bank & $past(wr_data[BW-1:0])) == $past(wr_data[BW-1:0])));

    // R4: a bit clear on the selector leaves every set data bit low.
    assert_bit_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == WOP_CLR && wr_addr == TOP_ADDR && !soft_rst)
        |=> ((bank & $past(wr_data[BW-1:0])) == '0));

endmodule

// File: rtl/spi_cmd_ctrl.sv
// Module: spi_cmd_ctrl
// Command sequencer: decodes the first byte of each chip-select frame and
// steps through the data bytes, producing register updates, buffer strobes,
// the soft-reset pulse and the next byte to transmit. Assumes buffer read
// data arrives one cycle after the read strobe.
module spi_cmd_ctrl
    import spi_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_active,
    input  logic              byte_done,
    input  logic [REG_W-1:0]  rx_byte,
    input  logic [BANK_W-1:0] bank,
    input  logic [REG_W-1:0]  rd_data,
    input  logic [REG_W-1:0]  buf_rdata,
    output logic [REG_W-1:0]  tx_byte,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              wr_en,
    output wr_kind_e          wr_kind,
    output logic [REG_W-1:0]  wr_data,
    output logic              soft_rst,
    output logic              buf_rd_stb,
    output logic              buf_wr_stb,
    output logic [REG_W-1:0]  buf_wdata
);

    typedef enum logic [2:0] {
        ST_CMD,
        ST_RD_DUMMY,
        ST_RD_REG,
        ST_RD_BUF,
        ST_WR_REG,
        ST_WR_BUF,
        ST_IGNORE
    } state_e;

    state_e           state;
    opcode_e          op;
    logic             buf_pend;
    logic [REG_W-1:0] buf_hold;

    assign op = opcode_e'(rx_byte[REG_W-1 -: OP_W]);

    // Command decode and per-byte sequencing within one chip-select frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_CMD;
            reg_addr   <= '0;
            wr_en      <= 1'b0;
            wr_kind    <= WOP_LOAD;
            wr_data    <= '0;
            soft_rst   <= 1'b0;
            buf_rd_stb <= 1'b0;
            buf_wr_stb <= 1'b0;
            buf_wdata  <= '0;
            buf_pend   <= 1'b0;
            buf_hold   <= '0;
        end else begin
            wr_en      <= 1'b0;
            soft_rst   <= 1'b0;
            buf_rd_stb <= 1'b0;
            buf_wr_stb <= 1'b0;
            buf_pend   <= buf_rd_stb;
            if (buf_pend) buf_hold <= buf_rdata;

            if (!cs_active) begin
                state <= ST_CMD;
            end else if (byte_done) begin
                case (state)
                    ST_CMD: begin
                        reg_addr <= rx_byte[ADDR_W-1:0];
                        if (rx_byte == CMD_SOFT_RESET) begin
                            soft_rst <= 1'b1;
                            state    <= ST_IGNORE;
                        end else begin
                            case (op)
                                OP_RD_REG: state <= needs_dummy(bank, rx_byte[ADDR_W-1:0])
                                                    ? ST_RD_DUMMY : ST_RD_REG;
                                OP_RD_BUF: begin
                                    buf_rd_stb <= 1'b1;
                                    state      <= ST_RD_BUF;
                                end
                                OP_WR_REG: begin
                                    wr_kind <= WOP_LOAD;
                                    state   <= ST_WR_REG;
                                end
                                OP_WR_BUF: state <= ST_WR_BUF;
                                OP_BIT_SET: begin
                                    wr_kind <= WOP_SET;
                                    state   <= ST_WR_REG;
                                end
                                OP_BIT_CLR: begin
                                    wr_kind <= WOP_CLR;
                                    state   <= ST_WR_REG;
                                end
                                default: state <= ST_IGNORE;
                            endcase
                        end
                    end
                    ST_RD_DUMMY: state <= ST_RD_REG;
                    ST_RD_BUF:   buf_rd_stb <= 1'b1;
                    ST_WR_REG: begin
                        wr_en   <= 1'b1;
                        wr_data <= rx_byte;
                        state   <= ST_IGNORE;
                    end
                    ST_WR_BUF: begin
                        buf_wr_stb <= 1'b1;
                        buf_wdata  <= rx_byte;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Byte offered to the shifter for the next byte slot.
    always_comb begin
        case (state)
            ST_RD_REG: tx_byte = rd_data;
            ST_RD_BUF: tx_byte = buf_hold;
            default:   tx_byte = '0;
        endcase
    end

    // R7/R8: buffer read and write strobes never coincide.
    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_rd_stb && buf_wr_stb));

    // R8: a write strobe always follows a completed byte.
    assert_wr_stb_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_stb |-> $past(byte_done));

    // R3: a register update always follows a completed byte.
    assert_reg_wr_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(byte_done));

    // R10: once chip select is released no action is issued.
    assert_idle_when_deselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> (!wr_en && !soft_rst && !buf_rd_stb && !buf_wr_stb));

endmodule

// File: rtl/spi_cmd_regbank.sv
// Module: spi_cmd_regbank (top)
// SPI mode-0 slave that decodes register and buffer commands against a
// four-bank register file. Assumes SCK runs well below clk (each SCK
// phase lasts at least eight clk cycles) and a buffer memory that answers
// a read strobe on the next cycle.
module spi_cmd_regbank
    import spi_regbank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_sck,
    input  logic             spi_cs_n,
    input  logic             spi_mosi,
    output logic             spi_miso,
    output logic             buf_rd_stb,
    input  logic [REG_W-1:0] buf_rdata,
    output logic             buf_wr_stb,
    output logic [REG_W-1:0] buf_wdata
);

    logic              sck_rise, sck_fall, cs_active, mosi_s;
    logic              byte_done;
    logic [REG_W-1:0]  rx_byte, tx_byte;
    logic [ADDR_W-1:0] reg_addr;
    logic              wr_en, soft_rst;
    wr_kind_e          wr_kind;
    logic [REG_W-1:0]  wr_data, rd_data;
    logic [BANK_W-1:0] bank;

    spi_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_in    (spi_sck),
        .cs_n_in   (spi_cs_n),
        .mosi_in   (spi_mosi),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .cs_active (cs_active),
        .mosi_s    (mosi_s)
    );

    spi_byte_shifter #(.W(REG_W)) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_active (cs_active),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .mosi_s    (mosi_s),
        .tx_byte   (tx_byte),
        .rx_byte   (rx_byte),
        .byte_done (byte_done),
        .miso      (spi_miso)
    );

    spi_cmd_ctrl i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_active  (cs_active),
        .byte_done  (byte_done),
        .rx_byte    (rx_byte),
        .bank       (bank),
        .rd_data    (rd_data),
        .buf_rdata  (buf_rdata),
        .tx_byte    (tx_byte),
        .reg_addr   (reg_addr),
        .wr_en      (wr_en),
        .wr_kind    (wr_kind),
        .wr_data    (wr_data),
        .soft_rst   (soft_rst),
        .buf_rd_stb (buf_rd_stb),
        .buf_wr_stb (buf_wr_stb),
        .buf_wdata  (buf_wdata)
    );

    spi_reg_file #(
        .DATA_W       (REG_W),
        .AW           (ADDR_W),
        .BANKS        (NBANKS),
        .FIRST_SHARED (SHARED_FIRST)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_en    (wr_en),
        .wr_kind  (wr_kind),
        .wr_addr  (reg_addr),
        .wr_data  (wr_data),
        .rd_addr  (reg_addr),
        .rd_data  (rd_data),
        .bank     (bank)
    );

    // R11: nothing is driven toward the host or the buffer while deselected.
    assert_quiet_deselected_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
        |=> (!spi_miso && !buf_wr_stb));

endmodule

// File: tb/test_spi_cmd_regbank.sv
module test_spi_cmd_regbank;

    localparam int HALF = 8;   // SCK half period in clk cycles

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       miso;
    logic       buf_rd_stb, buf_wr_stb;
    logic [7:0] buf_rdata = 8'h00;
    logic [7:0] buf_wdata;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0] bmem [32];
    logic [4:0] rptr = '0;
    logic [4:0] wptr = '0;
    int rd_cnt = 0;
    int wr_cnt = 0;

    always #4 clk = ~clk;   // 125 MHz

    spi_cmd_regbank i_spi_cmd_regbank (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_sck    (sck),
        .spi_cs_n   (cs_n),
        .spi_mosi   (mosi),
        .spi_miso   (miso),
        .buf_rd_stb (buf_rd_stb),
        .buf_rdata  (buf_rdata),
        .buf_wr_stb (buf_wr_stb),
        .buf_wdata  (buf_wdata)
    );

    // Buffer memory model: answers a read strobe on the next cycle.
    always @(posedge clk) begin
        if (buf_rd_stb) begin
            buf_rdata <= bmem[rptr];
            rptr <= rptr + 1'b1;
            rd_cnt <= rd_cnt + 1;
        end
        if (buf_wr_stb) begin
            bmem[wptr] <= buf_wdata;
            wptr <= wptr + 1'b1;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cs_low();
        @(negedge clk);
        sck = 1'b0;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_high();
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (3 * HALF) @(negedge clk);
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        spi_bits(tx, 8, rx);
    endtask

    task automatic cmd2(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] junk;
        cs_low();
        spi_byte(c, junk);
        spi_byte(d, junk);
        cs_high();
    endtask

    task automatic rd2(input logic [4:0] a, output logic [7:0] b0, output logic [7:0] b1);
        logic [7:0] junk;
        cs_low();
        spi_byte({3'b000, a}, junk);
        spi_byte(8'h00, b0);
        spi_byte(8'h00, b1);
        cs_high();
    endtask

    task automatic t_reset();
        logic [7:0] b0, b1;
        check("R11 miso idle", int'(miso), 0);
        rd2(5'h05, b0, b1);
        check("R11 reg 0x05", b0, 8'h00);
        rd2(5'h1F, b0, b1);
        check("R11 selector", b0, 8'h00);
        check("R11 no strobes", rd_cnt + wr_cnt, 0);
    endtask

    task automatic t_write_read();
        logic [7:0] b0, b1;
        cmd2(8'h45, 8'hA5);
        rd2(5'h05, b0, b1);
        check("R1 R2 first byte", b0, 8'hA5);
        check("R2 repeat byte", b1, 8'hA5);
    endtask

    task automatic t_extra_bytes();
        logic [7:0] b0, b1, junk;
        cs_low();
        spi_byte(8'h46, junk);
        spi_byte(8'h11, junk);
        spi_byte(8'h22, junk);
        cs_high();
        rd2(5'h06, b0, b1);
        check("R3 extra byte ignored", b0, 8'h11);
    endtask

    task automatic t_set_clr();
        logic [7:0] b0, b1;
        cmd2(8'h85, 8'h5A);
        rd2(5'h05, b0, b1);
        check("R4 bit set", b0, 8'hFF);
        cmd2(8'hA5, 8'h0F);
        rd2(5'h05, b0, b1);
        check("R4 bit clear", b0, 8'hF0);
    endtask

    task automatic t_banks();
        logic [7:0] b0, b1;
        cmd2(8'h5F, 8'h01);
        rd2(5'h05, b0, b1);
        check("R5 bank1 separate", b0, 8'h00);
        cmd2(8'h45, 8'h33);
        rd2(5'h05, b0, b1);
        check("R5 bank1 write", b0, 8'h33);
        cmd2(8'hBF, 8'h01);
        rd2(5'h05, b0, b1);
        check("R5 bank0 kept", b0, 8'hF0);
        cmd2(8'h5C, 8'h77);
        cmd2(8'h9F, 8'h01);
        rd2(5'h1C, b0, b1);
        check("R5 shared reg", b0, 8'h77);
        rd2(5'h1F, b0, b1);
        check("R5 selector value", b0, 8'h01);
    endtask

    task automatic t_dummy();
        logic [7:0] b0, b1;
        cmd2(8'h5F, 8'h02);
        cmd2(8'h43, 8'h9C);
        rd2(5'h03, b0, b1);
        check("R6 bank2 dummy", b0, 8'h00);
        check("R6 bank2 value", b1, 8'h9C);
        rd2(5'h1C, b0, b1);
        check("R6 shared no dummy", b0, 8'h77);
        cmd2(8'h5F, 8'h03);
        cmd2(8'h4A, 8'h41);
        rd2(5'h0A, b0, b1);
        check("R6 bank3 0x0A dummy", b0, 8'h00);
        check("R6 bank3 0x0A value", b1, 8'h41);
        cmd2(8'h45, 8'h18);
        rd2(5'h05, b0, b1);
        check("R6 bank3 0x05 value", b1, 8'h18);
        cmd2(8'h46, 8'h62);
        rd2(5'h06, b0, b1);
        check("R6 bank3 0x06 no dummy", b0, 8'h62);
        cmd2(8'h5F, 8'h00);
    endtask

    task automatic t_abort();
        logic [7:0] b0, b1, junk;
        cs_low();
        spi_byte(8'h45, junk);
        spi_bits(8'h0C, 5, junk);
        cs_high();
        rd2(5'h05, b0, b1);
        check("R10 data abort", b0, 8'hF0);
        cs_low();
        spi_bits(8'hFF, 6, junk);
        cs_high();
        rd2(5'h05, b0, b1);
        check("R10 command abort", b0, 8'hF0);
        cmd2(8'h45, 8'h3C);
        rd2(5'h05, b0, b1);
        check("R10 next frame clean", b0, 8'h3C);
    endtask

    task automatic t_undefined_ops();
        logic [7:0] b0, b1;
        cmd2(8'hC5, 8'hEE);
        cmd2(8'hE5, 8'h11);
        rd2(5'h05, b0, b1);
        check("R9 undefined opcodes", b0, 8'h3C);
    endtask

    task automatic t_rd_buf();
        logic [7:0] junk, got;
        logic [4:0] base;
        int cnt0;
        base = rptr;
        cnt0 = rd_cnt;
        cs_low();
        spi_byte(8'h3A, junk);
        for (int i = 0; i < 3; i++) begin
            spi_byte(8'h00, got);
            check("R7 buffer byte", got, bmem[base + 5'(i)]);
        end
        cs_high();
        check("R7 read strobe count", rd_cnt - cnt0, 4);
    endtask

    task automatic t_wr_buf();
        logic [7:0] junk;
        logic [4:0] base;
        int w0, r0;
        base = wptr;
        w0 = wr_cnt;
        r0 = rd_cnt;
        cs_low();
        spi_byte(8'h7A, junk);
        for (int i = 0; i < 3; i++) spi_byte(8'hC1 + 8'(i), junk);
        cs_high();
        check("R8 write strobe count", wr_cnt - w0, 3);
        check("R8 no read strobes", rd_cnt - r0, 0);
        for (int i = 0; i < 3; i++)
            check("R8 written byte", bmem[base + 5'(i)], 8'hC1 + i);
    endtask

    task automatic t_soft_reset();
        logic [7:0] b0, b1, junk;
        cmd2(8'h5F, 8'h01);
        cs_low();
        spi_byte(8'hFF, junk);
        cs_high();
        rd2(5'h1F, b0, b1);
        check("R9 selector cleared", b0, 8'h00);
        rd2(5'h05, b0, b1);
        check("R9 bank0 cleared", b0, 8'h00);
        rd2(5'h1C, b0, b1);
        check("R9 shared cleared", b0, 8'h00);
        cmd2(8'h5F, 8'h01);
        rd2(5'h05, b0, b1);
        check("R9 bank1 cleared", b0, 8'h00);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) bmem[i] = 8'(i * 7 + 1);
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_read();
        t_extra_bytes();
        t_set_clr();
        t_banks();
        t_dummy();
        t_abort();
        t_undefined_ops();
        t_rd_buf();
        t_wr_buf();
        t_soft_reset();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule